// File: doc/BRIEF.md
# Single/Dual Phase Pulse Decoder

This block sits in front of a counter channel. It turns the two phase pins of a pulse generator into one-cycle count-step strobes, each with a direction bit. Both pins first pass through a multi-flop synchronizer. The decoder then compares the synchronized phases with their values from the previous clock.

Two modes are supported. In single-phase mode only phase A matters. Both its rising and its falling edge each give one step, and a software-driven down-count command sets the direction. In quadrature mode, every legal change of either phase gives one step, which is four steps per full input cycle. The direction comes from which phase leads. If both phases change within the same sample, the transition cannot be decoded. No step is issued and a sticky error flag is set, which only reset clears.

The step strobe is a plain one-cycle pulse with no back-pressure. The counter downstream must accept a step on every clock, and at most one step is issued per clock. The mode select and the down-count command are synchronous control inputs.

Top module: `phase_step_decoder`

## Requirements
- R1: While reset is low, and for the first SYNC_STAGES+1 clocks after it is released, step_o, dir_down_o and err_o are 0 and no step is issued, whatever level the phase pins hold.
- R2: A single change on a phase pin that counts as a step makes step_o high for exactly one clock. step_o is high in the clock after the (SYNC_STAGES+1)-th rising edge following the change, which is the third edge with the default of 2.
- R3: In single-phase mode (quad_mode_i = 0), each rising edge and each falling edge of phase A gives one step, so one input pulse gives two steps.
- R4: In single-phase mode, the direction of a step is down (dir_down_o = 1) when down_cmd_i is 1, and up (dir_down_o = 0) when down_cmd_i is 0.
- R5: In single-phase mode, changes of phase B give no step and no error.
- R6: In quadrature mode (quad_mode_i = 1), each change of exactly one phase gives one step, so one full input cycle gives four steps. Changes on consecutive clocks give steps on consecutive clocks.
- R7: In quadrature mode, the phase pair {A,B} stepping through 00, 10, 11, 01 (A leads) gives up steps (dir_down_o = 0). Stepping through 00, 01, 11, 10 (B leads) gives down steps (dir_down_o = 1). down_cmd_i has no effect in this mode.
- R8: In quadrature mode, a sample in which both phases changed gives no step and sets err_o. err_o then stays 1 until reset, while legal changes keep producing steps.
- R9: A phase change that reaches the decoder in the same clock that quad_mode_i differs from its value one clock earlier gives no step and no error. The previous-phase state is still updated, so that change never produces a step later.
- R10: dir_down_o changes only in a clock in which step_o is high. Otherwise it holds the direction of the last step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a_i | input | 1 | Phase A pin, asynchronous |
| phase_b_i | input | 1 | Phase B pin, asynchronous |
| quad_mode_i | input | 1 | 0 = single-phase, 1 = quadrature |
| down_cmd_i | input | 1 | Down-count command for single-phase mode |
| step_o | output | 1 | One-clock count-step strobe |
| dir_down_o | output | 1 | Direction of the last step, 1 = down |
| err_o | output | 1 | Sticky illegal-quadrature-transition flag |

## Verification
The hardest case to reach is a mode switch that lands in exactly the clock in which a phase change leaves the synchronizer. The switch must come neither before the change is sampled nor after the decoder has acted on it. The stimulus changes the pin on a falling clock edge and flips the mode two falling edges later, just ahead of the decoding edge. It then confirms that the step is lost for good. The double-phase error needs a similar setup: both pins change on the same falling edge, so the two changes cross the synchronizer together.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic {
    PD_SINGLE = 1'b0,
    PD_QUAD   = 1'b1
  } pd_mode_e;

  typedef struct packed {
    logic a;
    logic b;
  } pd_phase_t;

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pd_single_dec.sv
module pd_single_dec (
  input  logic cur_a,
  input  logic prev_a,
  input  logic down_cmd,
  output logic hit,
  output logic down
);

  // Both edges of phase A count; the command alone sets the direction.
  always_comb begin
    hit  = cur_a ^ prev_a;
    down = down_cmd;
  end

endmodule

// File: rtl/pd_quad_dec.sv
module pd_quad_dec
  import pd_pkg::*;
(
  input  pd_phase_t cur,
  input  pd_phase_t prev,
  output logic      hit,
  output logic      bad,
  output logic      down
);

  logic chg_a;
  logic chg_b;

  always_comb begin
    chg_a = cur.a ^ prev.a;
    chg_b = cur.b ^ prev.b;
    hit   = chg_a ^ chg_b;
    bad   = chg_a & chg_b;
    // For a single-phase change, B leading A means the new B differs from the old A.
    down  = prev.a ^ cur.b;
  end

endmodule

// File: rtl/phase_step_decoder.sv
module phase_step_decoder
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_a_i,
  input  logic phase_b_i,
  input  logic quad_mode_i,
  input  logic down_cmd_i,
  output logic step_o,
  output logic dir_down_o,
  output logic err_o
);

  localparam int ARM_LEN = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_LEN + 1);
  localparam logic [ARM_W-1:0] ARM_TOP = ARM_W'(ARM_LEN);

  logic [1:0] sync_q;
  pd_phase_t  cur;
  pd_phase_t  prev;
  pd_mode_e   mode_now;
  pd_mode_e   mode_q;
  logic [ARM_W-1:0] arm_cnt;
  logic       armed;
  logic       gate;
  logic       s_hit, s_down;
  logic       q_hit, q_bad, q_down;
  logic       sel_hit, sel_bad, sel_down;

  pd_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({phase_a_i, phase_b_i}),
    .q    (sync_q)
  );

  assign cur      = pd_phase_t'(sync_q);
  assign mode_now = pd_mode_e'(quad_mode_i);

  pd_single_dec u_single (
    .cur_a   (cur.a),
    .prev_a  (prev.a),
    .down_cmd(down_cmd_i),
    .hit     (s_hit),
    .down    (s_down)
  );

  pd_quad_dec u_quad (
    .cur (cur),
    .prev(prev),
    .hit (q_hit),
    .bad (q_bad),
    .down(q_down)
  );

  always_comb begin
    armed = (arm_cnt == ARM_TOP);
    gate  = armed && (mode_now == mode_q);
    if (mode_now == PD_QUAD) begin
      sel_hit  = q_hit;
      sel_bad  = q_bad;
      sel_down = q_down;
    end else begin
      sel_hit  = s_hit;
      sel_bad  = 1'b0;
      sel_down = s_down;
    end
  end

  // Holds decoding off until the synchronizer and the previous-phase register carry pin data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= '0;
    end else if (!armed) begin
      arm_cnt <= arm_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev       <= '0;
      mode_q     <= PD_SINGLE;
      step_o     <= 1'b0;
      dir_down_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      prev   <= cur;
      mode_q <= mode_now;
      step_o <= gate && sel_hit;
      if (gate && sel_hit) begin
        dir_down_o <= sel_down;
      end
      if (gate && sel_bad) begin
        err_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic quad_mode_i,
  input logic down_cmd_i,
  input logic step_o,
  input logic dir_down_o,
  input logic err_o
);

  localparam int QUIET = SYNC_STAGES + 2;

  int cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0;
    end else if (cyc < QUIET) begin
      cyc <= cyc + 1;
    end
  end

  AST_ARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (cyc >= QUIET)); // R1

  AST_SINGLE_DIR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !$past(quad_mode_i)) |-> (dir_down_o == $past(down_cmd_i))); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R8

  AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !step_o); // R8

  AST_MODE_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(quad_mode_i) != $past(quad_mode_i, 2)) |-> !step_o); // R9

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_o |-> $stable(dir_down_o)); // R10

endmodule

bind phase_step_decoder pd_checker #(.SYNC_STAGES(SYNC_STAGES)) u_pd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .quad_mode_i(quad_mode_i),
  .down_cmd_i (down_cmd_i),
  .step_o     (step_o),
  .dir_down_o (dir_down_o),
  .err_o      (err_o)
);

// File: tb/phase_step_decoder_bench.sv
`timescale 1ns/1ps
module phase_step_decoder_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic pa, pb, qmode, dcmd;
  logic step, dir, err;

  int checks   = 0;
  int failures = 0;
  int step_cnt = 0;

  always #5 clk = ~clk;

  phase_step_decoder u_phase_step_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_a_i  (pa),
    .phase_b_i  (pb),
    .quad_mode_i(qmode),
    .down_cmd_i (dcmd),
    .step_o     (step),
    .dir_down_o (dir),
    .err_o      (err)
  );

  always @(negedge clk) begin
    if (rst_n && step) step_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {mode, down_cmd, A, B, expected step, expected dir}
  localparam int NV = 17;
  localparam logic [5:0] VEC [NV] = '{
    6'b0_0_10_1_0,  // R3 A rise, up
    6'b0_0_00_1_0,  // R3 A fall, up
    6'b0_1_10_1_1,  // R4 down command
    6'b0_1_11_0_1,  // R5 B rise ignored
    6'b0_1_01_1_1,  // R3 A fall, down
    6'b0_0_00_0_1,  // R5 B fall ignored, R10 dir holds
    6'b0_0_11_1_0,  // R5 both change in single mode: A counts, no error
    6'b0_0_01_1_0,  // R3
    6'b1_0_01_0_0,  // mode switch with stable pins
    6'b1_1_00_1_0,  // R7 up, down_cmd ignored
    6'b1_0_10_1_0,  // R6 R7 up
    6'b1_0_11_1_0,  // R6 R7 up
    6'b1_0_01_1_0,  // R6 R7 up
    6'b1_0_11_1_1,  // R7 down
    6'b1_1_10_1_1,  // R7 down
    6'b1_0_00_1_1,  // R7 down
    6'b1_0_01_1_1   // R7 down
  };

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; pa = 1'b1; pb = 1'b1; qmode = 1'b0; dcmd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 step in reset", step, 0);
    chk("R1 dir in reset", dir, 0);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 no step after release with pins high", step_cnt, 0);
    chk("R1 err after release", err, 0);

    rst_n = 1'b0; pa = 1'b0; pb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 no step after second release", step_cnt, 0);

    for (int i = 0; i < NV; i++) begin
      qmode = VEC[i][5]; dcmd = VEC[i][4]; pa = VEC[i][3]; pb = VEC[i][2];
      repeat (3) @(negedge clk);
      chk($sformatf("R2 R3 R5 R6 vec%0d step", i), step, VEC[i][1]);
      chk($sformatf("R4 R7 R10 vec%0d dir", i), dir, VEC[i][0]);
      chk($sformatf("R5 R8 vec%0d err", i), err, 0);
      @(negedge clk);
      chk($sformatf("R2 vec%0d single-cycle step", i), step, 0);
    end

    // R8: both phases change together in quadrature mode (01 -> 10)
    base = step_cnt;
    pa = 1'b1; pb = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 no step on double change", step_cnt - base, 0);
    chk("R8 err set", err, 1);
    pb = 1'b1;  // 10 -> 11, up
    repeat (3) @(negedge clk);
    chk("R8 legal step after error", step, 1);
    chk("R8 up dir after error", dir, 0);
    chk("R8 err sticky", err, 1);
    repeat (3) @(negedge clk);
    chk("R8 err still set", err, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 R1 err cleared by reset", err, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R9: mode flips in the clock that decodes an A fall (quad 11 -> 01)
    base = step_cnt;
    pa = 1'b0;
    repeat (2) @(negedge clk);
    qmode = 1'b0;
    @(negedge clk);
    chk("R9 step dropped at mode switch", step, 0);
    repeat (4) @(negedge clk);
    chk("R9 no late step", step_cnt - base, 0);
    chk("R9 no error", err, 0);
    dcmd = 1'b1; pa = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 R4 step after switch", step, 1);
    chk("R9 R4 down dir after switch", dir, 1);

    // R6: burst on consecutive clocks in quadrature, up from 11
    qmode = 1'b1; dcmd = 1'b0;
    repeat (4) @(negedge clk);
    base = step_cnt;
    pa = 1'b0; pb = 1'b1; @(negedge clk);
    pa = 1'b0; pb = 1'b0; @(negedge clk);
    pa = 1'b1; pb = 1'b0; @(negedge clk);
    pa = 1'b1; pb = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 four steps in burst", step_cnt - base, 4);
    chk("R7 burst dir up", dir, 0);
    chk("R6 burst no error", err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule